// File: doc/BRIEF.md
# Port Flush Engine for an Address Table

The block removes one or more switch ports from every entry of an address lookup table. Given a 3-bit flush mask, it walks the table from index 0 to the last index. For each entry it reads the word, decides what to change and writes the result back to the same index. Unicast address entries owned by a flushed port are released. Multicast address entries lose the flushed ports from their port set, and an entry whose port set becomes empty is released.

A second mode touches multicast entries only. In this mode the walk can be limited to one VLAN, and broadcast entries are never changed. The table is reached through a read-modify-write port: a read request, a returned word one cycle later, and a write request. A one-cycle start pulse launches the walk. A one-cycle done pulse marks the end.

Entry layout (72 bits):

| Bits  | Field                                             |
|-------|---------------------------------------------------|
| 47:0  | MAC address                                       |
| 40    | multicast flag (group bit of the MAC)             |
| 59:48 | VLAN ID                                           |
| 61:60 | kind: 0 free, 1 address, 2 VLAN, 3 address with VLAN |
| 68:66 | multicast port set; bits 67:66 also hold the unicast owner port number |

Top module: `port_flush_engine`

## Requirements
- R1: After reset, busy, done, tbl_rd_en and tbl_wr_en are all 0. No table access occurs while the engine is idle.
- R2: Entries whose kind field (bits 61:60) is 0 (free) or 2 (VLAN) are written back unchanged.
- R3: This applies in full mode (mc_only=0) to an address entry (kind 1 or 3) with bit 40 clear. If bit (bits 67:66) of the flush mask is set, the kind field is cleared to 0. An owner number of 3 never matches.
- R4: A multicast address entry (bit 40 set) is left unchanged when its port set (bits 68:66) has no bit in common with the flush mask.
- R5: A multicast entry whose port set shares bits with the flush mask has those bits cleared. If the remaining set is empty, the old set is kept and the kind field becomes 0. Otherwise the remaining set is stored. In full mode this also applies to broadcast entries.
- R6: In multicast-only mode (mc_only=1), unicast entries are untouched. Multicast entries are processed only when flush_vid is 12'hFFF or equals bits 59:48.
- R7: In multicast-only mode, an entry whose MAC (bits 47:0) is all ones is never modified.
- R8: Each entry takes three cycles: read, modify, write. There is exactly one write per index. done is high for one cycle, 3*DEPTH cycles after the edge that accepts start.
- R9: start is ignored while a walk is in progress. The mask, mode and VLAN are captured when start is accepted.
- R10: Every bit not named in R3 and R5 (bits 71:69, 65:62, 59:0) is written back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | pulse that launches a walk when idle |
| flush_mask | input | 3 | ports to remove |
| mc_only | input | 1 | 1 selects multicast-only mode |
| flush_vid | input | 12 | VLAN filter for multicast-only mode; 12'hFFF means any |
| busy | output | 1 | walk in progress |
| done | output | 1 | one-cycle end-of-walk pulse |
| tbl_addr | output | IDX_W | table index for read and write |
| tbl_rd_en | output | 1 | read request; data is returned the next cycle |
| tbl_rdata | input | 72 | entry returned by the table |
| tbl_wr_en | output | 1 | write request |
| tbl_wdata | output | 72 | entry written back |

## Verification
The main walk runs in three scenarios.

- **Full mode with a single-port mask.** The table mixes:
  - free and VLAN entries;
  - unicast owners 0, 1 and 3;
  - multicast sets that overlap partly, fully or not at all;
  - a broadcast entry.

  This scenario separates release from partial stripping from no change. It also exposes any wrong indexing of the owner number.
- **Multicast-only mode with a specific VLAN.** This shows whether the VLAN compare, the broadcast exemption and unicast immunity are honoured.
- **Multicast-only mode with the all-ones VLAN.** This confirms the wildcard.

Directed runs cover two further points. One measures the cycle of done and the count of writes. The other changes the inputs and pulses start in the middle of a walk, to show that the captured configuration governs the result.

// File: rtl/port_flush_engine.sv
module port_flush_engine #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENTRY_W = 72
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         flush_mask,
  input  logic               mc_only,
  input  logic [11:0]        flush_vid,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   tbl_addr,
  output logic               tbl_rd_en,
  input  logic [ENTRY_W-1:0] tbl_rdata,
  output logic               tbl_wr_en,
  output logic [ENTRY_W-1:0] tbl_wdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_MOD, S_WR, S_DONE} state_t;

  state_t               state;
  logic [IDX_W-1:0]     idx;
  logic [2:0]           cfg_mask;
  logic                 cfg_mc;
  logic [11:0]          cfg_vid;
  logic [ENTRY_W-1:0]   ent;
  logic [ENTRY_W-1:0]   nxt;

  wire [1:0]  kind     = tbl_rdata[61:60];
  wire        is_addr  = (kind == 2'd1) || (kind == 2'd3);
  wire        is_mc    = tbl_rdata[40];
  wire [2:0]  pset     = tbl_rdata[68:66];
  wire [1:0]  owner    = tbl_rdata[67:66];
  wire        vid_ok   = (&cfg_vid) || (tbl_rdata[59:48] == cfg_vid);
  wire        is_bcast = &tbl_rdata[47:0];
  wire [3:0]  mask4    = {1'b0, cfg_mask};
  wire        uc_hit   = mask4[owner];
  wire [2:0]  pleft    = pset & ~cfg_mask;
  wire        overlap  = |(pset & cfg_mask);
  wire        mc_act   = is_addr && is_mc && (!cfg_mc || (vid_ok && !is_bcast));
  wire        uc_act   = is_addr && !is_mc && !cfg_mc;

  always_comb begin
    nxt = tbl_rdata;
    if (mc_act && overlap) begin
      if (pleft == 3'b000) nxt[61:60] = 2'd0;
      else                 nxt[68:66] = pleft;
    end
    if (uc_act && uc_hit) nxt[61:60] = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      cfg_mask <= '0;
      cfg_mc   <= 1'b0;
      cfg_vid  <= '0;
      ent      <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state    <= S_RD;
          idx      <= '0;
          cfg_mask <= flush_mask;
          cfg_mc   <= mc_only;
          cfg_vid  <= flush_vid;
        end
        S_RD:  state <= S_MOD;
        S_MOD: begin
          ent   <= nxt;
          state <= S_WR;
        end
        S_WR: begin
          if (idx == LAST_IDX) state <= S_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state == S_RD) || (state == S_MOD) || (state == S_WR);
  assign done      = (state == S_DONE);
  assign tbl_rd_en = (state == S_RD);
  assign tbl_wr_en = (state == S_WR);
  assign tbl_addr  = idx;
  assign tbl_wdata = ent;
endmodule

module port_flush_engine_chk #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] tbl_addr,
  input logic             tbl_rd_en,
  input logic [71:0]      tbl_rdata,
  input logic             tbl_wr_en,
  input logic [71:0]      tbl_wdata
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!tbl_rd_en && !tbl_wr_en)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rst_n) !(tbl_rd_en && tbl_wr_en)); // R8
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) tbl_wr_en |-> ($past(tbl_rd_en, 2) && tbl_addr == $past(tbl_addr, 2))); // R8
  AST_KEEP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n) tbl_wr_en |-> (tbl_wdata[59:0] == $past(tbl_rdata[59:0]) && tbl_wdata[71:69] == $past(tbl_rdata[71:69]) && tbl_wdata[65:62] == $past(tbl_rdata[65:62]))); // R10
  AST_NO_PORT_GAIN: assert property (@(posedge clk) disable iff (!rst_n) tbl_wr_en |-> ((tbl_wdata[68:66] & ~$past(tbl_rdata[68:66])) == 3'b000)); // R5
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && !done) |=> busy); // R9
endmodule

bind port_flush_engine port_flush_engine_chk #(.DEPTH(DEPTH)) chk (.*);

// File: tb/port_flush_engine_test.sv
module port_flush_engine_test;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NV = 18;

  function automatic logic [71:0] mk(input logic [2:0] top, input logic [2:0] ps,
      input logic [3:0] mid, input logic [1:0] ty, input logic [11:0] vid, input logic [47:0] mac);
    return {top, ps, mid, ty, vid, mac};
  endfunction

  localparam logic [47:0] U = 48'h0000_1234_5678;
  localparam logic [47:0] M = 48'h0100_5E00_0001;
  localparam logic [47:0] B = 48'hFFFF_FFFF_FFFF;

  localparam logic [71:0] VIN [NV] = '{
    mk(5,3'b010,4'hA,0,1,U), mk(5,3'b010,4'hA,2,1,U), mk(5,3'b001,4'hA,1,1,U),
    mk(5,3'b000,4'hA,3,1,U), mk(5,3'b011,4'hA,1,1,U), mk(5,3'b110,4'hA,1,1,M),
    mk(5,3'b010,4'hA,3,1,M), mk(5,3'b101,4'hA,1,1,M), mk(5,3'b010,4'hA,1,1,B),
    mk(5,3'b101,4'hA,1,1,U),
    mk(0,3'b111,4'h3,1,5,M), mk(0,3'b111,4'h3,1,6,M), mk(0,3'b011,4'h3,1,5,B),
    mk(0,3'b001,4'h3,1,5,U), mk(0,3'b001,4'h3,3,5,M),
    mk(0,3'b111,4'h0,1,6,M), mk(0,3'b100,4'h0,3,9,M), mk(0,3'b100,4'h0,1,9,B)};
  localparam logic [71:0] VEXP [NV] = '{
    mk(5,3'b010,4'hA,0,1,U), mk(5,3'b010,4'hA,2,1,U), mk(5,3'b001,4'hA,0,1,U),
    mk(5,3'b000,4'hA,3,1,U), mk(5,3'b011,4'hA,1,1,U), mk(5,3'b100,4'hA,1,1,M),
    mk(5,3'b010,4'hA,0,1,M), mk(5,3'b101,4'hA,1,1,M), mk(5,3'b010,4'hA,0,1,B),
    mk(5,3'b101,4'hA,0,1,U),
    mk(0,3'b100,4'h3,1,5,M), mk(0,3'b111,4'h3,1,6,M), mk(0,3'b011,4'h3,1,5,B),
    mk(0,3'b001,4'h3,1,5,U), mk(0,3'b001,4'h3,0,5,M),
    mk(0,3'b011,4'h0,1,6,M), mk(0,3'b100,4'h0,0,9,M), mk(0,3'b100,4'h0,1,9,B)};
  localparam string VREQ [NV] = '{"R2","R2","R3","R3","R3","R5","R5","R4","R5","R10",
    "R6","R6","R7","R6","R5","R6","R5","R7"};
  localparam int VGRP [NV] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,1,2,2,2};
  localparam logic [2:0]  GMASK [3] = '{3'b010, 3'b011, 3'b100};
  localparam logic        GMC   [3] = '{1'b0, 1'b1, 1'b1};
  localparam logic [11:0] GVID  [3] = '{12'h000, 12'h005, 12'hFFF};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mc_only = 1'b0;
  logic [2:0] flush_mask = '0;
  logic [11:0] flush_vid = '0;
  logic busy, done, tbl_rd_en, tbl_wr_en;
  logic [IDX_W-1:0] tbl_addr;
  logic [71:0] tbl_rdata = '0, tbl_wdata;
  logic [71:0] mem [DEPTH];
  int checks = 0, fails = 0, wr_cnt = 0, cyc, base;

  always #4 clk = ~clk;

  port_flush_engine #(.DEPTH(DEPTH)) uut (.*);

  always @(posedge clk) begin
    if (tbl_rd_en) tbl_rdata <= mem[tbl_addr];
    if (tbl_wr_en) begin
      mem[tbl_addr] <= tbl_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_group(input int g);
    int slot = 0;
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    for (int v = 0; v < NV; v++)
      if (VGRP[v] == g) begin
        mem[slot] = VIN[v];
        slot++;
      end
  endtask

  task automatic run(input logic [2:0] m, input logic mc, input logic [11:0] vid, input bit disturb);
    @(negedge clk);
    flush_mask = m; mc_only = mc; flush_vid = vid; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (disturb && cyc == 7) begin
        start = 1'b1; flush_mask = 3'b111; mc_only = 1'b1; flush_vid = 12'hFFF;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
  endtask

  task automatic check_group(input int g, input string tag_override);
    int slot = 0;
    for (int v = 0; v < NV; v++)
      if (VGRP[v] == g) begin
        check(mem[slot] === VEXP[v], tag_override == "" ? VREQ[v] : tag_override, mem[slot], VEXP[v]);
        slot++;
      end
    for (int i = slot; i < DEPTH; i++) check(mem[i] === '0, "R2", mem[i], '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !tbl_rd_en && !tbl_wr_en, "R1",
          {68'd0, busy, done, tbl_rd_en, tbl_wr_en}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !tbl_rd_en && !tbl_wr_en, "R1",
          {68'd0, busy, done, tbl_rd_en, tbl_wr_en}, '0);

    for (int g = 0; g < 3; g++) begin
      load_group(g);
      base = wr_cnt;
      run(GMASK[g], GMC[g], GVID[g], 1'b0);
      check(cyc == 3*DEPTH, "R8", 72'(cyc), 72'(3*DEPTH));
      check(wr_cnt - base == DEPTH, "R8", 72'(wr_cnt - base), 72'(DEPTH));
      @(negedge clk);
      check(!done && !busy, "R8", {70'd0, done, busy}, '0);
      check_group(g, "");
    end

    load_group(0);
    run(GMASK[0], GMC[0], GVID[0], 1'b1);
    check(cyc == 3*DEPTH, "R9", 72'(cyc), 72'(3*DEPTH));
    @(negedge clk);
    @(negedge clk);
    check(!busy && !done, "R9", {70'd0, busy, done}, '0);
    check_group(0, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule